// File: doc/BRIEF.md
# Linear CCD Line Readout Timing Generator

This block drives a three-colour linear CCD sensor whose three rows (red, green, blue) are read out in parallel from the same clocks. From a faster system clock it produces the complementary pair of shift clocks, a last-stage clock, an active-low reset-gate pulse, an active-low clamp pulse and one transfer-gate pulse shared by the three rows. Every width, window and guard interval is a system-clock count on a configuration input, so one netlist serves any pixel rate between 1 MHz and 6 MHz.

A pulse on `start` requests one line. The block runs a static guard interval, then the transfer pulse, then a second static guard. After that it clocks out the pixel periods. During readout it reports a pixel index and a region flag for each pixel. The regions come in a fixed order: leading dummy pixels, optical black, two invalid pixels, the valid pixels, and three trailing invalid pixels. The block also gives the ADC one sample strobe per pixel period. A request that arrives while a line is in progress is held and starts the next line as soon as the current one ends. Two clamp schemes are selectable. In the per-pixel scheme the clamp pulses in every pixel period. In the per-line scheme the clamp is the inverse of the transfer pulse and reset pulses are withheld while it is low.

All outputs are registered. Each output reflects the sequencer state one system clock earlier. The block has no data stream of its own, so it has no valid/ready handshake. The strobe is a plain single-cycle pulse that the ADC side cannot stall. Configuration inputs should be changed only while the block is idle.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset, and whenever no line is in progress, `sh1`=1, `sh2`=0, `sh1_last`=1, `rg_n`=1, `cl_n`=1, `tgate`=0, `adc_strobe`=0, all region flags are 0 and `pix_idx`=0.
- R2: A `start` sampled while idle begins a line with `cfg_guard` cycles of static clocks. These are followed by `cfg_tg_len` cycles with `tgate`=1, then another `cfg_guard` static cycles, then readout. During the guards and the transfer, `sh1`=1 and `sh2`=0. A count of 0 behaves as 1.
- R3: Each readout pixel period lasts `cfg_pix_len` cycles, counted from position 0. `sh1` is 1 for positions below `cfg_sh1_len` and 0 otherwise. `sh2` is always the inverse of `sh1`, and `sh1_last` always equals `sh1`.
- R4: During readout, `rg_n` is 0 exactly at positions p with `cfg_rg_at` ≤ p < `cfg_rg_at`+`cfg_rg_len`. Outside readout `rg_n` is 1, including during the transfer.
- R5: With `line_mode`=0 (per-pixel clamp), `cl_n` is 0 during readout exactly at positions p with `cfg_cl_at` ≤ p < `cfg_cl_at`+`cfg_cl_len`. Outside readout `cl_n` is 1.
- R6: With `line_mode`=1 (per-line clamp), `cl_n` equals the inverse of `tgate` at all times, and `rg_n` stays 1 whenever `cl_n` is 0.
- R7: `pix_idx` counts readout pixels from 0. With the default parameters the regions are laid out as follows. Indices below 15 carry no flag. The next 49 indices have `is_black`=1. The next 2 have `is_invalid`=1. The next 5400 have `is_valid`=1. The next 3 have `is_invalid`=1. Any index after those carries no flag. At most one flag is set at a time.
- R8: A line holds max(`cfg_line_pix`, minimum) pixel periods. The minimum is the sum of the five region sizes, which is 5469 with the default parameters.
- R9: A `start` that arrives during a line is held. The next line's first guard begins in the cycle after the current line's last pixel period. Several such requests collapse into one line.
- R10: `adc_strobe` is 1 for exactly one cycle per readout pixel period, at position `cfg_smp_at`, and never outside readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Active-low reset, asynchronous assert |
| start | input | 1 | Line request |
| line_mode | input | 1 | 0: per-pixel clamp, 1: per-line clamp |
| cfg_pix_len | input | CW | System clocks per pixel period |
| cfg_sh1_len | input | CW | Cycles with `sh1` high at the start of a pixel period |
| cfg_rg_at | input | CW | Position of the reset pulse in the pixel period |
| cfg_rg_len | input | CW | Width of the reset pulse |
| cfg_cl_at | input | CW | Position of the per-pixel clamp pulse |
| cfg_cl_len | input | CW | Width of the per-pixel clamp pulse |
| cfg_smp_at | input | CW | Position of the ADC strobe |
| cfg_tg_len | input | CW | Transfer pulse width |
| cfg_guard | input | CW | Static guard before and after the transfer |
| cfg_line_pix | input | PIXW | Requested pixel periods per line |
| sh1 | output | 1 | Shift clock phase 1 |
| sh2 | output | 1 | Shift clock phase 2 |
| sh1_last | output | 1 | Last-stage shift clock |
| rg_n | output | 1 | Reset-gate pulse, active low |
| cl_n | output | 1 | Clamp pulse, active low |
| tgate | output | 1 | Transfer-gate pulse, all three rows |
| adc_strobe | output | 1 | ADC sample strobe |
| pix_idx | output | PIXW | Readout pixel index |
| is_black | output | 1 | Optical-black pixel |
| is_invalid | output | 1 | Invalid pixel |
| is_valid | output | 1 | Valid pixel |

## Verification
The bench builds the block with 2 leading dummy pixels, 3 optical-black pixels, 2 and 3 invalid pixels and 8 valid pixels, for a minimum line of 18 periods. With these sizes every region boundary, the line-length floor and back-to-back held requests all occur within a few hundred cycles. Pixel periods of 6 and 8 cycles with different window placements cover both clamp schemes. They also cover a requested line length both above and below the floor, and zero-count configuration values that must act as one cycle.

// File: rtl/ccd_tg_pkg.sv
`timescale 1ns/1ps
package ccd_tg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_XFER  = 3'd2,
    PH_TRAIL = 3'd3,
    PH_READ  = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    RG_DUMMY = 3'd0,
    RG_BLACK = 3'd1,
    RG_INV   = 3'd2,
    RG_VALID = 3'd3,
    RG_OVER  = 3'd4
  } region_e;
endpackage

// File: rtl/ccd_phase_seq.sv
`timescale 1ns/1ps
module ccd_phase_seq
  import ccd_tg_pkg::*;
#(
  parameter int CW      = 16,
  parameter int PIXW    = 14,
  parameter int MIN_PIX = 5469
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            start,
  input  logic [CW-1:0]   cfg_guard,
  input  logic [CW-1:0]   cfg_tg_len,
  input  logic [CW-1:0]   cfg_pix_len,
  input  logic [PIXW-1:0] cfg_line_pix,
  output phase_e          phase,
  output logic [CW-1:0]   cnt,
  output logic [PIXW-1:0] pix
);
  localparam logic [PIXW-1:0] MIN_P = PIXW'(MIN_PIX);

  phase_e          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [PIXW-1:0] pix_q, pix_d;
  logic            pend_q, pend_d;
  logic [PIXW-1:0] eff_pix;
  logic            pix_last;

  // A count of zero is treated as one cycle.
  function automatic logic span_done(input logic [CW-1:0] c, input logic [CW-1:0] len);
    return ({1'b0, c} + {{CW{1'b0}}, 1'b1}) >= {1'b0, len};
  endfunction

  assign eff_pix  = (cfg_line_pix > MIN_P) ? cfg_line_pix : MIN_P;
  assign pix_last = ({1'b0, pix_q} + {{PIXW{1'b0}}, 1'b1}) >= {1'b0, eff_pix};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    pix_d   = pix_q;
    pend_d  = pend_q | start;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) begin
          phase_d = PH_LEAD;
          pend_d  = 1'b0;
        end
      end
      PH_LEAD: if (span_done(cnt_q, cfg_guard)) begin
        phase_d = PH_XFER;
        cnt_d   = '0;
      end
      PH_XFER: if (span_done(cnt_q, cfg_tg_len)) begin
        phase_d = PH_TRAIL;
        cnt_d   = '0;
      end
      PH_TRAIL: if (span_done(cnt_q, cfg_guard)) begin
        phase_d = PH_READ;
        cnt_d   = '0;
        pix_d   = '0;
      end
      PH_READ: if (span_done(cnt_q, cfg_pix_len)) begin
        cnt_d = '0;
        pix_d = pix_q + 1'b1;
        if (pix_last) begin
          pix_d = '0;
          if (pend_q || start) begin
            phase_d = PH_LEAD;
            pend_d  = 1'b0;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pix_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      pix_q   <= pix_d;
      pend_q  <= pend_d;
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;
  assign pix   = pix_q;
endmodule

// File: rtl/ccd_region_map.sv
`timescale 1ns/1ps
module ccd_region_map
  import ccd_tg_pkg::*;
#(
  parameter int PIXW     = 14,
  parameter int LEAD     = 15,
  parameter int BLACK    = 49,
  parameter int PRE_INV  = 2,
  parameter int VALID    = 5400,
  parameter int POST_INV = 3
) (
  input  logic [PIXW-1:0] pix,
  output region_e         region
);
  localparam int E_LEAD  = LEAD;
  localparam int E_BLACK = E_LEAD + BLACK;
  localparam int E_PRE   = E_BLACK + PRE_INV;
  localparam int E_VALID = E_PRE + VALID;
  localparam int E_POST  = E_VALID + POST_INV;

  always_comb begin
    if (pix < PIXW'(E_LEAD))       region = RG_DUMMY;
    else if (pix < PIXW'(E_BLACK)) region = RG_BLACK;
    else if (pix < PIXW'(E_PRE))   region = RG_INV;
    else if (pix < PIXW'(E_VALID)) region = RG_VALID;
    else if (pix < PIXW'(E_POST))  region = RG_INV;
    else                           region = RG_OVER;
  end
endmodule

// File: rtl/ccd_pixel_wave.sv
`timescale 1ns/1ps
module ccd_pixel_wave
  import ccd_tg_pkg::*;
#(
  parameter int CW   = 16,
  parameter int PIXW = 14
) (
  input  logic            clk,
  input  logic            arst_n,
  input  phase_e          phase,
  input  logic [CW-1:0]   cnt,
  input  logic [PIXW-1:0] pix,
  input  region_e         region,
  input  logic            line_mode,
  input  logic [CW-1:0]   cfg_sh1_len,
  input  logic [CW-1:0]   cfg_rg_at,
  input  logic [CW-1:0]   cfg_rg_len,
  input  logic [CW-1:0]   cfg_cl_at,
  input  logic [CW-1:0]   cfg_cl_len,
  input  logic [CW-1:0]   cfg_smp_at,
  output logic            sh1,
  output logic            sh2,
  output logic            sh1_last,
  output logic            rg_n,
  output logic            cl_n,
  output logic            tgate,
  output logic            adc_strobe,
  output logic [PIXW-1:0] pix_idx,
  output logic            is_black,
  output logic            is_invalid,
  output logic            is_valid
);
  logic in_read, in_xfer, s1_d, rg_d, cl_d;

  function automatic logic in_win(input logic [CW-1:0] c, input logic [CW-1:0] at,
                                  input logic [CW-1:0] len);
    return ({1'b0, c} >= {1'b0, at}) && ({1'b0, c} < ({1'b0, at} + {1'b0, len}));
  endfunction

  always_comb begin
    in_read = (phase == PH_READ);
    in_xfer = (phase == PH_XFER);
    s1_d    = in_read ? (cnt < cfg_sh1_len) : 1'b1;
    cl_d    = line_mode ? !in_xfer : !(in_read && in_win(cnt, cfg_cl_at, cfg_cl_len));
    rg_d    = !(in_read && in_win(cnt, cfg_rg_at, cfg_rg_len) && (cl_d || !line_mode));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh1        <= 1'b1;
      sh2        <= 1'b0;
      sh1_last   <= 1'b1;
      rg_n       <= 1'b1;
      cl_n       <= 1'b1;
      tgate      <= 1'b0;
      adc_strobe <= 1'b0;
      pix_idx    <= '0;
      is_black   <= 1'b0;
      is_invalid <= 1'b0;
      is_valid   <= 1'b0;
    end else begin
      sh1        <= s1_d;
      sh2        <= !s1_d;
      sh1_last   <= s1_d;
      rg_n       <= rg_d;
      cl_n       <= cl_d;
      tgate      <= in_xfer;
      adc_strobe <= in_read && (cnt == cfg_smp_at);
      pix_idx    <= in_read ? pix : '0;
      is_black   <= in_read && (region == RG_BLACK);
      is_invalid <= in_read && (region == RG_INV);
      is_valid   <= in_read && (region == RG_VALID);
    end
  end
endmodule

// File: rtl/ccd_line_timer.sv
`timescale 1ns/1ps
module ccd_line_timer
  import ccd_tg_pkg::*;
#(
  parameter int CW           = 16,
  parameter int LEAD_PIX     = 15,
  parameter int BLACK_PIX    = 49,
  parameter int PRE_INV_PIX  = 2,
  parameter int VALID_PIX    = 5400,
  parameter int POST_INV_PIX = 3,
  localparam int MIN_PIX     = LEAD_PIX + BLACK_PIX + PRE_INV_PIX + VALID_PIX + POST_INV_PIX,
  localparam int PIXW        = $clog2(MIN_PIX + 1) + 1
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            start,
  input  logic            line_mode,
  input  logic [CW-1:0]   cfg_pix_len,
  input  logic [CW-1:0]   cfg_sh1_len,
  input  logic [CW-1:0]   cfg_rg_at,
  input  logic [CW-1:0]   cfg_rg_len,
  input  logic [CW-1:0]   cfg_cl_at,
  input  logic [CW-1:0]   cfg_cl_len,
  input  logic [CW-1:0]   cfg_smp_at,
  input  logic [CW-1:0]   cfg_tg_len,
  input  logic [CW-1:0]   cfg_guard,
  input  logic [PIXW-1:0] cfg_line_pix,
  output logic            sh1,
  output logic            sh2,
  output logic            sh1_last,
  output logic            rg_n,
  output logic            cl_n,
  output logic            tgate,
  output logic            adc_strobe,
  output logic [PIXW-1:0] pix_idx,
  output logic            is_black,
  output logic            is_invalid,
  output logic            is_valid
);
  phase_e          phase;
  logic [CW-1:0]   cnt;
  logic [PIXW-1:0] pix;
  region_e         region;

  ccd_phase_seq #(.CW(CW), .PIXW(PIXW), .MIN_PIX(MIN_PIX)) u_seq (
    .clk(clk), .arst_n(arst_n), .start(start),
    .cfg_guard(cfg_guard), .cfg_tg_len(cfg_tg_len), .cfg_pix_len(cfg_pix_len),
    .cfg_line_pix(cfg_line_pix),
    .phase(phase), .cnt(cnt), .pix(pix)
  );

  ccd_region_map #(
    .PIXW(PIXW), .LEAD(LEAD_PIX), .BLACK(BLACK_PIX), .PRE_INV(PRE_INV_PIX),
    .VALID(VALID_PIX), .POST_INV(POST_INV_PIX)
  ) u_map (
    .pix(pix), .region(region)
  );

  ccd_pixel_wave #(.CW(CW), .PIXW(PIXW)) u_wave (
    .clk(clk), .arst_n(arst_n), .phase(phase), .cnt(cnt), .pix(pix), .region(region),
    .line_mode(line_mode), .cfg_sh1_len(cfg_sh1_len), .cfg_rg_at(cfg_rg_at),
    .cfg_rg_len(cfg_rg_len), .cfg_cl_at(cfg_cl_at), .cfg_cl_len(cfg_cl_len),
    .cfg_smp_at(cfg_smp_at),
    .sh1(sh1), .sh2(sh2), .sh1_last(sh1_last), .rg_n(rg_n), .cl_n(cl_n),
    .tgate(tgate), .adc_strobe(adc_strobe), .pix_idx(pix_idx),
    .is_black(is_black), .is_invalid(is_invalid), .is_valid(is_valid)
  );
endmodule

// File: rtl/ccd_line_timer_chk.sv
`timescale 1ns/1ps
module ccd_line_timer_chk (
  input logic clk,
  input logic arst_n,
  input logic line_mode,
  input logic sh1,
  input logic sh2,
  input logic sh1_last,
  input logic rg_n,
  input logic cl_n,
  input logic tgate,
  input logic adc_strobe,
  input logic is_black,
  input logic is_invalid,
  input logic is_valid
);
  AST_XFER_CLOCKS_PARKED: assert property (@(posedge clk) disable iff (!arst_n)
    tgate |-> (sh1 && !sh2 && sh1_last)); // R2
  AST_XFER_CLOCKS_STEADY: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(tgate) |-> ($stable(sh1) && $stable(sh2))); // R2
  AST_LAST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (!arst_n)
    sh1_last == sh1); // R3
  AST_XFER_RESET_HIGH: assert property (@(posedge clk) disable iff (!arst_n)
    tgate |-> rg_n); // R4
  AST_BIT_CLAMP_IDLE_IN_XFER: assert property (@(posedge clk) disable iff (!arst_n)
    (tgate && !$past(line_mode)) |-> cl_n); // R5
  AST_LINE_CLAMP_INVERSE: assert property (@(posedge clk) disable iff (!arst_n)
    $past(line_mode) |-> (cl_n == !tgate)); // R6
  AST_LINE_CLAMP_NO_RESET: assert property (@(posedge clk) disable iff (!arst_n)
    (!cl_n && $past(line_mode)) |-> rg_n); // R6
  AST_REGION_EXCLUSIVE: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({is_black, is_invalid, is_valid})); // R7
  AST_STROBE_NOT_IN_XFER: assert property (@(posedge clk) disable iff (!arst_n)
    adc_strobe |-> !tgate); // R10
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    adc_strobe |=> !adc_strobe); // R10
endmodule

bind ccd_line_timer ccd_line_timer_chk u_chk (
  .clk(clk), .arst_n(arst_n), .line_mode(line_mode),
  .sh1(sh1), .sh2(sh2), .sh1_last(sh1_last), .rg_n(rg_n), .cl_n(cl_n),
  .tgate(tgate), .adc_strobe(adc_strobe),
  .is_black(is_black), .is_invalid(is_invalid), .is_valid(is_valid)
);

// File: tb/ccd_line_timer_tb.sv
`timescale 1ns/1ps
module ccd_line_timer_tb;
  localparam int CW = 16;
  localparam int NL = 2, NB = 3, NPI = 2, NV = 8, NPO = 3;
  localparam int MINP = NL + NB + NPI + NV + NPO;
  localparam int PW = $clog2(MINP + 1) + 1;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic start = 1'b0;
  logic line_mode = 1'b0;
  logic [CW-1:0] cfg_pix_len, cfg_sh1_len, cfg_rg_at, cfg_rg_len, cfg_cl_at, cfg_cl_len;
  logic [CW-1:0] cfg_smp_at, cfg_tg_len, cfg_guard;
  logic [PW-1:0] cfg_line_pix;
  logic sh1, sh2, sh1_last, rg_n, cl_n, tgate, adc_strobe, is_black, is_invalid, is_valid;
  logic [PW-1:0] pix_idx;

  always #2.5 clk = ~clk;

  ccd_line_timer #(.CW(CW), .LEAD_PIX(NL), .BLACK_PIX(NB), .PRE_INV_PIX(NPI),
                   .VALID_PIX(NV), .POST_INV_PIX(NPO)) u_dut (
    .clk(clk), .arst_n(arst_n), .start(start), .line_mode(line_mode),
    .cfg_pix_len(cfg_pix_len), .cfg_sh1_len(cfg_sh1_len), .cfg_rg_at(cfg_rg_at),
    .cfg_rg_len(cfg_rg_len), .cfg_cl_at(cfg_cl_at), .cfg_cl_len(cfg_cl_len),
    .cfg_smp_at(cfg_smp_at), .cfg_tg_len(cfg_tg_len), .cfg_guard(cfg_guard),
    .cfg_line_pix(cfg_line_pix),
    .sh1(sh1), .sh2(sh2), .sh1_last(sh1_last), .rg_n(rg_n), .cl_n(cl_n), .tgate(tgate),
    .adc_strobe(adc_strobe), .pix_idx(pix_idx), .is_black(is_black),
    .is_invalid(is_invalid), .is_valid(is_valid)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // Behavioural reference: st 0 idle, 1 first guard, 2 transfer, 3 second guard, 4 readout
  int m_st, m_c, m_p;
  bit m_pend;
  int e_sh1, e_rg, e_cl, e_tg, e_stb, e_idx, e_blk, e_inv, e_val;
  // per-line tallies observed at the ports
  int n_stb, n_blk, n_inv, n_val, n_tg_rise, n_tg_cyc;
  logic tg_prev;

  function automatic int region_of(input int p);
    if (p < NL) return 0;
    if (p < NL + NB) return 1;
    if (p < NL + NB + NPI) return 2;
    if (p < NL + NB + NPI + NV) return 3;
    if (p < MINP) return 2;
    return 0;
  endfunction

  function automatic bit fin(input int c, input int len);
    return (c + 1) >= len;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_st = 0; m_c = 0; m_p = 0; m_pend = 0;
      e_sh1 = 1; e_rg = 1; e_cl = 1; e_tg = 0; e_stb = 0; e_idx = 0;
      e_blk = 0; e_inv = 0; e_val = 0;
    end else begin
      int eff, rgn;
      bit rd, rgw, clw;
      rd  = (m_st == 4);
      rgn = region_of(m_p);
      e_sh1 = rd ? (m_c < int'(cfg_sh1_len)) : 1;
      clw = rd && m_c >= int'(cfg_cl_at) && m_c < int'(cfg_cl_at) + int'(cfg_cl_len);
      rgw = rd && m_c >= int'(cfg_rg_at) && m_c < int'(cfg_rg_at) + int'(cfg_rg_len);
      e_cl  = line_mode ? (m_st != 2) : !clw;
      e_rg  = !rgw;
      e_tg  = (m_st == 2);
      e_stb = rd && (m_c == int'(cfg_smp_at));
      e_idx = rd ? m_p : 0;
      e_blk = rd && rgn == 1;
      e_inv = rd && rgn == 2;
      e_val = rd && rgn == 3;
      eff = (int'(cfg_line_pix) > MINP) ? int'(cfg_line_pix) : MINP;
      m_pend = m_pend | start;
      case (m_st)
        0: if (start) begin m_st = 1; m_c = 0; m_pend = 0; end
        1: if (fin(m_c, cfg_guard)) begin m_st = 2; m_c = 0; end else m_c++;
        2: if (fin(m_c, cfg_tg_len)) begin m_st = 3; m_c = 0; end else m_c++;
        3: if (fin(m_c, cfg_guard)) begin m_st = 4; m_c = 0; m_p = 0; end else m_c++;
        default: if (fin(m_c, cfg_pix_len)) begin
          m_c = 0;
          if (m_p + 1 >= eff) begin
            m_p = 0;
            if (m_pend) begin m_st = 1; m_pend = 0; end else m_st = 0;
          end else m_p++;
        end else m_c++;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (arst_n && !finished) begin
      cyc++;
      chk("R3", "sh1", sh1, e_sh1);
      chk("R3", "sh2", sh2, !e_sh1);
      chk("R3", "sh1_last", sh1_last, e_sh1);
      chk("R4", "rg_n", rg_n, e_rg);
      chk(line_mode ? "R6" : "R5", "cl_n", cl_n, e_cl);
      chk("R2", "tgate", tgate, e_tg);
      chk("R10", "adc_strobe", adc_strobe, e_stb);
      chk("R7", "pix_idx", int'(pix_idx), e_idx);
      chk("R7", "is_black", is_black, e_blk);
      chk("R7", "is_invalid", is_invalid, e_inv);
      chk("R7", "is_valid", is_valid, e_val);
      if (adc_strobe) n_stb++;
      if (adc_strobe && is_black) n_blk++;
      if (adc_strobe && is_invalid) n_inv++;
      if (adc_strobe && is_valid) n_val++;
      if (tgate) n_tg_cyc++;
      if (tgate && !tg_prev) n_tg_rise++;
      tg_prev = tgate;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        summary();
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic clear_tallies();
    n_stb = 0; n_blk = 0; n_inv = 0; n_val = 0; n_tg_rise = 0; n_tg_cyc = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(m_st == 0 && !m_pend));
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input int pl, input int s1, input int ra, input int rl, input int ca,
                         input int cll, input int sa, input int tl, input int gd, input int lp);
    cfg_pix_len = CW'(pl); cfg_sh1_len = CW'(s1); cfg_rg_at = CW'(ra); cfg_rg_len = CW'(rl);
    cfg_cl_at = CW'(ca); cfg_cl_len = CW'(cll); cfg_smp_at = CW'(sa);
    cfg_tg_len = CW'(tl); cfg_guard = CW'(gd); cfg_line_pix = PW'(lp);
  endtask

  initial begin
    tg_prev = 1'b0;
    clear_tallies();
    set_cfg(6, 3, 0, 1, 1, 1, 4, 5, 3, 20);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "reset sh1", sh1, 1); chk("R1", "reset sh2", sh2, 0);
    chk("R1", "reset rg_n", rg_n, 1); chk("R1", "reset cl_n", cl_n, 1);
    chk("R1", "reset tgate", tgate, 0); chk("R1", "reset strobe", adc_strobe, 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle sh1", sh1, 1);
    chk("R1", "idle pix_idx", int'(pix_idx), 0);

    // Line 1: per-pixel clamp, requested length above floor (R2, R7, R8, R10)
    clear_tallies(); pulse_start(); wait_idle();
    chk("R8", "strobes per 20-pixel line", n_stb, 20);
    chk("R7", "black pixels", n_blk, NB);
    chk("R7", "invalid pixels", n_inv, NPI + NPO);
    chk("R7", "valid pixels", n_val, NV);
    chk("R2", "transfer cycles", n_tg_cyc, 5);

    // Requests during a line are held and merged (R9)
    clear_tallies(); pulse_start();
    repeat (60) @(negedge clk);
    pulse_start(); repeat (5) @(negedge clk); pulse_start();
    wait_idle();
    chk("R9", "lines from held requests", n_tg_rise, 2);
    chk("R9", "strobes over two lines", n_stb, 40);

    // Per-line clamp, length below floor (R6, R8)
    line_mode = 1'b1;
    set_cfg(8, 4, 1, 2, 0, 3, 6, 4, 2, 4);
    clear_tallies(); pulse_start(); wait_idle();
    chk("R8", "floor line length", n_stb, MINP);
    chk("R6", "transfer cycles line mode", n_tg_cyc, 4);
    chk("R6", "clamp idle after line", cl_n, 1);

    // Zero counts act as one cycle, wide clamp window in bit mode (R2, R5)
    line_mode = 1'b0;
    set_cfg(7, 2, 5, 2, 2, 3, 0, 0, 0, 18);
    clear_tallies(); pulse_start(); wait_idle();
    chk("R2", "zero transfer count is one cycle", n_tg_cyc, 1);
    chk("R10", "strobes per floor line", n_stb, MINP);
    chk("R1", "idle rg_n after line", rg_n, 1);
    summary();
  end
endmodule